// File: doc/BRIEF.md
# Cache-Block Operation Engine

This block owns a small direct-mapped write-back data cache and carries out maintenance work on one cache block per request. A request names an operation and a byte address. The engine reduces the address to its naturally aligned block, looks the line up, and runs one of the following operations:

- discard the line;
- push dirty data out to memory and keep the line;
- push dirty data out and then discard the line, as one uninterrupted step;
- fill the whole block with zeros as a store;
- write a single 32-bit word into a resident line;
- accept a prefetch hint and do nothing with it.

Dirty data leaves through a plain memory write port, one 32-bit word per beat.

Requests use a valid/ready handshake. Ready is high only while the engine is idle. Once a request is taken, ready stays low until the one-cycle done pulse, so back-pressure on the request side covers the whole operation, including every memory beat. The memory write port is also valid/ready. A beat that is offered stays offered, with the same address and data, until memory raises ready. The engine waits without limit on each beat.

Top module: `cbo_engine`

## Requirements
- R1: Opcode 0 (invalidate) on a hit clears the line's valid and dirty state and issues no memory write, even when the line is dirty. On a miss it changes nothing.
- R2: Opcode 1 (clean) on a hit to a dirty line writes all BLOCK_BYTES/4 words of the line to memory, at the block's base address in ascending word order. It leaves the line valid and not dirty. On a clean line or on a miss it issues no memory write.
- R3: Opcode 2 (flush) performs the clean of R2 and then invalidates the line. No other request is accepted between the two steps.
- R4: Opcode 3 (zero) leaves every word of the block zero and the line valid, dirty and tagged with the request's address, allocating the line on a miss. If the miss evicts a valid dirty line with another tag, that victim is written back to its own address first.
- R5: Address bits below the block size never cause an error. They do not change which line invalidate, clean, flush or zero act on. Address bits [4:2] (the word index, for the default 32-byte block) select the word for opcode 4.
- R6: After a clean or flush has completed, a further clean or flush of the same line issues no memory write until a zero or a word store modifies the line again.
- R7: While mem_wvalid is high and mem_wready is low, mem_wvalid, mem_waddr and mem_wdata hold steady into the next cycle.
- R8: req_ready is high only when idle, goes low in the cycle after a request is accepted, and stays low until done has pulsed for exactly one cycle.
- R9: Opcode 4 (word store) on a hit writes req_wdata into the selected word and marks the line dirty. On a miss it has no effect. Opcode 5 (prefetch hint), and codes 6 and 7, complete with no effect on the cache or memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_op | input | 3 | Operation code (see R1 to R9) |
| req_addr | input | ADDR_W | Byte address inside the target block |
| req_wdata | input | 32 | Data for the word store |
| done | output | 1 | One-cycle completion pulse |
| mem_wvalid | output | 1 | Memory write beat offered |
| mem_wready | input | 1 | Memory accepts the beat |
| mem_waddr | output | ADDR_W | Word-aligned byte address of the beat |
| mem_wdata | output | 32 | Data of the beat |

## Verification
The following rules are checked on every cycle by assertions:

- the stall-hold rule of the memory port;
- ready staying low after acceptance, and done lasting one cycle;
- invalidate never producing write traffic;
- dirty lines always being valid;
- a discarded line reading back invalid and clean;
- a zeroed line reading back valid, dirty and tagged.

Some behaviours only the directed scenarios can show, because they depend on the data that reaches memory:

- whether a write-back happens at all, and with which words;
- that a dirty line's data is lost on invalidate;
- that a second clean stays silent;
- that a zero on a miss evicts the right victim.

These scenarios compare the whole memory image against an independent model after every request.

// File: rtl/cbo_pkg.sv
package cbo_pkg;
  typedef enum logic [2:0] {
    OP_INVAL = 3'd0,
    OP_CLEAN = 3'd1,
    OP_FLUSH = 3'd2,
    OP_ZERO  = 3'd3,
    OP_STORE = 3'd4,
    OP_HINT  = 3'd5
  } cbo_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WB,
    ST_DONE
  } cbo_state_e;
endpackage

// File: rtl/cbo_tag_store.sv
module cbo_tag_store #(
  parameter int LINES = 4,
  parameter int TAG_W = 9,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_valid,
  input  logic             upd_dirty,
  input  logic [TAG_W-1:0] upd_tag
);
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[i] <= 1'b0;
        dirty_q[i] <= 1'b0;
        tag_q[i]   <= '0;
      end else if (upd_en && upd_idx == IDX_W'(i)) begin
        valid_q[i] <= upd_valid;
        dirty_q[i] <= upd_dirty;
        tag_q[i]   <= upd_tag;
      end
    end

    AST_DIRTY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      dirty_q[i] |-> valid_q[i]); // R2
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
endmodule

// File: rtl/cbo_line_data.sv
module cbo_line_data #(
  parameter int LINES = 4,
  parameter int WORDS = 8,
  localparam int IDX_W  = $clog2(LINES),
  localparam int WORD_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [WORD_W-1:0] rd_word,
  output logic [31:0]       rd_data,
  input  logic              zero_en,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [31:0]       wr_data
);
  logic [31:0] words_q [LINES][WORDS];

  for (genvar l = 0; l < LINES; l++) begin : g_line
    for (genvar w = 0; w < WORDS; w++) begin : g_word
      always_ff @(posedge clk) begin
        if (zero_en && wr_idx == IDX_W'(l))
          words_q[l][w] <= '0;
        else if (wr_en && wr_idx == IDX_W'(l) && wr_word == WORD_W'(w))
          words_q[l][w] <= wr_data;
      end
    end
  end

  assign rd_data = words_q[rd_idx][rd_word];
endmodule

// File: rtl/cbo_ctrl.sv
module cbo_ctrl
  import cbo_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int TAG_W  = 9,
  parameter int IDX_W  = 2,
  parameter int WORD_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              done,
  output logic [IDX_W-1:0]  line_idx,
  input  logic              line_valid,
  input  logic              line_dirty,
  input  logic [TAG_W-1:0]  line_tag,
  output logic [WORD_W-1:0] rd_word,
  input  logic [31:0]       rd_data,
  output logic              tag_upd_en,
  output logic              tag_upd_valid,
  output logic              tag_upd_dirty,
  output logic [TAG_W-1:0]  tag_upd_tag,
  output logic              dat_zero_en,
  output logic              dat_wr_en,
  output logic [WORD_W-1:0] dat_wr_word,
  output logic [31:0]       dat_wr_data,
  output logic              mem_wvalid,
  input  logic              mem_wready,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [31:0]       mem_wdata
);
  localparam int OFF_W = WORD_W + 2;
  localparam logic [WORD_W-1:0] LAST_BEAT = '1;

  cbo_state_e        state_q;
  logic [2:0]        op_q;
  logic [TAG_W-1:0]  tag_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] word_q;
  logic [31:0]       wdata_q;
  logic [WORD_W-1:0] beat_q;
  logic              hit;
  logic              need_wb;

  assign hit = line_valid && (line_tag == tag_q);

  always_comb begin
    unique case (op_q)
      OP_CLEAN, OP_FLUSH: need_wb = hit && line_dirty;
      OP_ZERO:            need_wb = !hit && line_valid && line_dirty;
      default:            need_wb = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      tag_q   <= '0;
      idx_q   <= '0;
      word_q  <= '0;
      wdata_q <= '0;
      beat_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid) begin
          op_q    <= req_op;
          tag_q   <= req_addr[ADDR_W-1 -: TAG_W];
          idx_q   <= req_addr[OFF_W +: IDX_W];
          word_q  <= req_addr[2 +: WORD_W];
          wdata_q <= req_wdata;
          state_q <= ST_LOOK;
        end
        ST_LOOK: begin
          beat_q  <= '0;
          state_q <= need_wb ? ST_WB : ST_DONE;
        end
        ST_WB: if (mem_wready) begin
          beat_q <= beat_q + 1'b1;
          if (beat_q == LAST_BEAT) state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign done       = (state_q == ST_DONE);
  assign line_idx   = idx_q;
  assign rd_word    = beat_q;
  assign mem_wvalid = (state_q == ST_WB);
  assign mem_waddr  = {line_tag, idx_q, beat_q, 2'b00};
  assign mem_wdata  = rd_data;

  // All cache state changes land in the completion cycle, after any write-back.
  always_comb begin
    tag_upd_en    = 1'b0;
    tag_upd_valid = 1'b0;
    tag_upd_dirty = 1'b0;
    tag_upd_tag   = tag_q;
    dat_zero_en   = 1'b0;
    dat_wr_en     = 1'b0;
    dat_wr_word   = word_q;
    dat_wr_data   = wdata_q;
    if (state_q == ST_DONE) begin
      unique case (op_q)
        OP_INVAL, OP_FLUSH: tag_upd_en = hit;
        OP_CLEAN: begin
          tag_upd_en    = hit;
          tag_upd_valid = 1'b1;
        end
        OP_ZERO: begin
          tag_upd_en    = 1'b1;
          tag_upd_valid = 1'b1;
          tag_upd_dirty = 1'b1;
          dat_zero_en   = 1'b1;
        end
        OP_STORE: begin
          tag_upd_en    = hit;
          tag_upd_valid = 1'b1;
          tag_upd_dirty = 1'b1;
          dat_wr_en     = hit;
        end
        default: ;
      endcase
    end
  end

  AST_WB_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wvalid && !mem_wready) |=> (mem_wvalid && $stable(mem_waddr) && $stable(mem_wdata))); // R7
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_INVAL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid |-> (op_q != OP_INVAL)); // R1
  AST_KILL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_upd_en && !tag_upd_valid) |=> (!line_valid && !line_dirty)); // R3
  AST_ZERO_OWNS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_ZERO) |=> (line_valid && line_dirty && line_tag == $past(tag_q))); // R4
endmodule

// File: rtl/cbo_engine.sv
module cbo_engine #(
  parameter int ADDR_W      = 16,
  parameter int LINES       = 4,
  parameter int BLOCK_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              done,
  output logic              mem_wvalid,
  input  logic              mem_wready,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [31:0]       mem_wdata
);
  localparam int WORDS  = BLOCK_BYTES / 4;
  localparam int WORD_W = $clog2(WORDS);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - WORD_W - 2 - IDX_W;

  logic [IDX_W-1:0]  line_idx;
  logic              line_valid, line_dirty;
  logic [TAG_W-1:0]  line_tag;
  logic [WORD_W-1:0] rd_word;
  logic [31:0]       rd_data;
  logic              tag_upd_en, tag_upd_valid, tag_upd_dirty;
  logic [TAG_W-1:0]  tag_upd_tag;
  logic              dat_zero_en, dat_wr_en;
  logic [WORD_W-1:0] dat_wr_word;
  logic [31:0]       dat_wr_data;

  cbo_ctrl #(
    .ADDR_W(ADDR_W), .TAG_W(TAG_W), .IDX_W(IDX_W), .WORD_W(WORD_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .done(done),
    .line_idx(line_idx), .line_valid(line_valid), .line_dirty(line_dirty),
    .line_tag(line_tag), .rd_word(rd_word), .rd_data(rd_data),
    .tag_upd_en(tag_upd_en), .tag_upd_valid(tag_upd_valid),
    .tag_upd_dirty(tag_upd_dirty), .tag_upd_tag(tag_upd_tag),
    .dat_zero_en(dat_zero_en), .dat_wr_en(dat_wr_en),
    .dat_wr_word(dat_wr_word), .dat_wr_data(dat_wr_data),
    .mem_wvalid(mem_wvalid), .mem_wready(mem_wready),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  cbo_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(line_idx), .rd_valid(line_valid), .rd_dirty(line_dirty), .rd_tag(line_tag),
    .upd_en(tag_upd_en), .upd_idx(line_idx), .upd_valid(tag_upd_valid),
    .upd_dirty(tag_upd_dirty), .upd_tag(tag_upd_tag)
  );

  cbo_line_data #(.LINES(LINES), .WORDS(WORDS)) u_data (
    .clk(clk),
    .rd_idx(line_idx), .rd_word(rd_word), .rd_data(rd_data),
    .zero_en(dat_zero_en), .wr_en(dat_wr_en), .wr_idx(line_idx),
    .wr_word(dat_wr_word), .wr_data(dat_wr_data)
  );
endmodule

// File: tb/tb_cbo_engine.sv
`timescale 1ns/1ps
module tb_cbo_engine;
  localparam int ADDR_W = 16;
  localparam int NWORDS = 1 << (ADDR_W - 2);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = '0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        done;
  logic        mem_wvalid;
  logic        mem_wready = 1'b1;
  logic [15:0] mem_waddr;
  logic [31:0] mem_wdata;

  int total = 0;
  int bad = 0;
  int beats = 0;
  bit stall_mode = 0;

  logic [31:0] mem_img [NWORDS];
  logic [31:0] ref_mem [NWORDS];
  bit          rv [4];
  bit          rdy [4];
  logic [8:0]  rt [4];
  logic [31:0] rdat [4][8];

  always #2.5 clk = ~clk;

  cbo_engine dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .done(done),
    .mem_wvalid(mem_wvalid), .mem_wready(mem_wready),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  always @(posedge clk) begin
    if (mem_wvalid && mem_wready) begin
      mem_img[mem_waddr[15:2]] = mem_wdata;
      beats++;
    end
  end

  always @(negedge clk) mem_wready <= stall_mode ? ~mem_wready : 1'b1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ref_wb(input int idx);
    for (int w = 0; w < 8; w++) ref_mem[{rt[idx], 2'(idx), 3'(w)}] = rdat[idx][w];
  endtask

  task automatic do_op(input logic [2:0] op, input logic [15:0] addr,
                       input logic [31:0] wd, input string req);
    int idx = int'(addr[6:5]);
    logic [8:0] tg = addr[15:7];
    int wi = int'(addr[4:2]);
    bit hit = rv[idx] && rt[idx] == tg;
    int exp_beats = 0;
    int busy_ready = 0;
    int cyc = 0;
    int diffs = 0;
    case (op)
      3'd0: if (hit) begin rv[idx] = 0; rdy[idx] = 0; end
      3'd1: if (hit && rdy[idx]) begin ref_wb(idx); exp_beats = 8; rdy[idx] = 0; end
      3'd2: if (hit) begin
              if (rdy[idx]) begin ref_wb(idx); exp_beats = 8; end
              rv[idx] = 0; rdy[idx] = 0;
            end
      3'd3: begin
              if (!hit && rv[idx] && rdy[idx]) begin ref_wb(idx); exp_beats = 8; end
              rv[idx] = 1; rdy[idx] = 1; rt[idx] = tg;
              for (int w = 0; w < 8; w++) rdat[idx][w] = '0;
            end
      3'd4: if (hit) begin rdat[idx][wi] = wd; rdy[idx] = 1; end
      default: ;
    endcase
    beats = 0;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done && cyc < 300) begin
      if (req_ready) busy_ready++;
      cyc++;
      @(negedge clk);
    end
    check(done, {req, " done pulse"}, int'(done), 1);
    check(busy_ready == 0, {req, " ready low while busy (R8)"}, busy_ready, 0);
    check(beats == exp_beats, {req, " write beats"}, beats, exp_beats);
    for (int i = 0; i < NWORDS; i++) if (mem_img[i] !== ref_mem[i]) diffs++;
    check(diffs == 0, {req, " memory image"}, diffs, 0);
    @(negedge clk);
    check(req_ready && !done, {req, " back to idle, done one cycle (R8)"}, int'(req_ready), 1);
  endtask

  task automatic t_reset();
    check(req_ready === 1'b1, "R8 reset ready", int'(req_ready), 1);
    check(done === 1'b0 && mem_wvalid === 1'b0, "R8 reset outputs quiet", int'(done), 0);
  endtask

  task automatic t_zero_alloc();
    do_op(3'd3, 16'h1220, 0, "R4 zero on miss allocates");
    do_op(3'd1, 16'h1220, 0, "R4 zeros reach memory on clean");
  endtask

  task automatic t_store_clean();
    do_op(3'd4, 16'h1224, 32'hDEAD_BEEF, "R9 store hit word1");
    do_op(3'd4, 16'h123C, 32'h1234_5678, "R9 store hit word7");
    do_op(3'd4, 16'h5524, 32'hFFFF_0000, "R9 store miss ignored");
    do_op(3'd1, 16'h1233, 0, "R2 clean dirty line");
  endtask

  task automatic t_clean_again();
    do_op(3'd1, 16'h1220, 0, "R6 second clean silent");
    do_op(3'd2, 16'h1220, 0, "R6 flush of clean line silent");
    do_op(3'd1, 16'h1220, 0, "R1 clean after flush misses");
  endtask

  task automatic t_flush();
    do_op(3'd3, 16'h4040, 0, "R4 zero line idx2");
    do_op(3'd4, 16'h4048, 32'hCAFE_0001, "R9 store idx2");
    do_op(3'd2, 16'h4041, 0, "R3 flush dirty line");
    do_op(3'd1, 16'h4040, 0, "R3 line gone after flush");
  endtask

  task automatic t_inval_dirty();
    do_op(3'd3, 16'h0860, 0, "R4 zero line idx3");
    do_op(3'd4, 16'h0864, 32'h0BAD_F00D, "R9 store idx3");
    do_op(3'd0, 16'h087E, 0, "R1 inval dirty no write");
    do_op(3'd2, 16'h0860, 0, "R1 dirty data discarded");
    do_op(3'd0, 16'h0860, 0, "R1 inval miss no effect");
  endtask

  task automatic t_zero_evict();
    do_op(3'd3, 16'h2000, 0, "R4 zero idx0");
    do_op(3'd4, 16'h2010, 32'hAAAA_5555, "R9 store idx0");
    do_op(3'd3, 16'h6000, 0, "R4 zero evicts dirty victim");
    do_op(3'd3, 16'h6000, 0, "R4 zero hit no traffic");
  endtask

  task automatic t_stall();
    stall_mode = 1;
    do_op(3'd4, 16'h6004, 32'h7777_8888, "R7 store before stalled clean");
    do_op(3'd1, 16'h6000, 0, "R7 clean under memory stalls");
    stall_mode = 0;
  endtask

  task automatic t_misaligned();
    do_op(3'd3, 16'h3A3F, 0, "R5 zero odd address");
    do_op(3'd4, 16'h3A2D, 32'h0102_0304, "R5 store word3 via odd address");
    do_op(3'd2, 16'h3A31, 0, "R5 flush odd offset");
  endtask

  task automatic t_hint();
    do_op(3'd3, 16'h1820, 0, "R9 zero before hint");
    do_op(3'd5, 16'h1820, 0, "R9 prefetch hint no effect");
    do_op(3'd7, 16'h1820, 0, "R9 unused code no effect");
    do_op(3'd1, 16'h1820, 0, "R9 line still dirty after hints");
  endtask

  initial begin
    for (int i = 0; i < NWORDS; i++) begin
      mem_img[i] = 32'hA500_0000 | i;
      ref_mem[i] = 32'hA500_0000 | i;
    end
    for (int l = 0; l < 4; l++) begin rv[l] = 0; rdy[l] = 0; rt[l] = '0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero_alloc();
    t_store_clean();
    t_clean_again();
    t_flush();
    t_inval_dirty();
    t_zero_evict();
    t_stall();
    t_misaligned();
    t_hint();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule